// File: doc/BRIEF.md
# Calendar Counter with Century Roll

This block keeps the time-of-day and calendar registers of a PC-style real-time clock: seconds, minutes, hours, weekday, day of month, month, two-digit year and century. Each pulse on the update strobe advances the seconds by one. A carry ripples upward through the minutes, hours, days, months and years in the same cycle, so the whole register set reaches its new value in one clock.

The same counters work with either packed-BCD or plain binary register contents. The hours register can hold 24-hour values, or 12-hour values with a PM flag. Software loads any register through a simple write port. When the two-digit year wraps, the century register is loaded with twenty.

Top module: `cal_counter`

## Requirements
- R1: After synchronous reset the registers hold, in hex: seconds 00, minutes 00, hours 00, weekday 03, day 01, month 01, year 80, century 19 (BCD values).
- R2: Each cycle with `upd_stb` high and `wr_en` low advances seconds by one. Seconds 59 wraps to 0 and carries into minutes. Minutes 59 wraps to 0 and carries into hours.
- R3: With `bin_mode` = 1 all registers are plain binary (for example, 09 steps to 0A). With `bin_mode` = 0 they are packed BCD (09 steps to 10).
- R4: With `fmt_24h` = 1 hours run 0 to 23. Hour 23 wraps to 0 and carries into the day.
- R5: With `fmt_24h` = 0, bit 7 of the hours register is the PM flag and bits 6:0 hold 1..12. Hour 11 AM steps to 12 PM (flag set), 12 PM steps to 1 PM, 11 PM steps to 12 AM (flag clear) and carries into the day, and 12 AM steps to 1 AM.
- R6: On a day carry, the weekday advances 1..7, and 7 wraps to 1.
- R7: On a day carry, the day of month wraps to 1 and carries into the month after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months. In February it wraps after day 29 when the year is divisible by 4, and after day 28 otherwise.
- R8: Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0.
- R9: When the year wraps, century bits 6:0 load the encoded value 20 (hex 20 in BCD, hex 14 in binary). Bit 7 keeps its previous value.
- R10: `wr_en` stores `wr_data` into the register selected by `wr_sel` on the next edge. The select codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 century. No other register changes, and an update strobe in the same cycle is ignored.
- R11: With neither `upd_stb` nor `wr_en` high, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | One-cycle strobe that advances time by one second |
| bin_mode | input | 1 | 1 = binary register contents, 0 = BCD |
| fmt_24h | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM flag in bit 7 |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| sec_q | output | 8 | Seconds |
| min_q | output | 8 | Minutes |
| hour_q | output | 8 | Hours |
| wday_q | output | 8 | Day of week |
| mday_q | output | 8 | Day of month |
| mon_q | output | 8 | Month |
| year_q | output | 8 | Year within century |
| cent_q | output | 8 | Century |

## Verification
The counter is driven from preloaded states that sit one strobe before a boundary. Single steps across a digit boundary separate BCD adjustment from binary counting. A complete end-of-year rollover in each encoding shows that the carry chain ripples all the way into the century. In the binary rollover, the century is preloaded with bit 7 set, which shows that bit 7 is kept while the rest is reloaded. End-of-month cases for February in leap and common years, a 30-day month, and a 31-day month mid-month show that the day limit follows the month and year. A set of 12-hour cases at 11 and 12 o'clock separates the PM flag behaviour from plain hour counting. A write that arrives together with a strobe shows which of the two has priority.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_WDAY = 3'd3,
        F_MDAY = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6, F_CENT = 3'd7
    } field_e;

    typedef struct packed {
        logic [DW-1:0] sec;
        logic [DW-1:0] min;
        logic [DW-1:0] hour;
        logic [DW-1:0] wday;
        logic [DW-1:0] mday;
        logic [DW-1:0] mon;
        logic [DW-1:0] year;
        logic [DW-1:0] cent;
    } cal_regs_t;

    // register contents -> binary count
    function automatic logic [DW-1:0] to_bin(input logic [DW-1:0] v, input logic bin);
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        hi = {4'd0, v[7:4]};
        lo = {4'd0, v[3:0]};
        return bin ? v : (hi * 8'd10 + lo);
    endfunction

    // binary count (< 100) -> register contents
    function automatic logic [DW-1:0] enc(input logic [DW-1:0] b, input logic bin);
        logic [DW-1:0] t;
        logic [DW-1:0] u;
        t = b / 8'd10;
        u = b % 8'd10;
        return bin ? b : {t[3:0], u[3:0]};
    endfunction

    function automatic logic [DW-1:0] month_len(input logic [DW-1:0] m, input logic leap);
        case (m)
            8'd2:                    return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

    function automatic logic [DW-1:0] pick(input cal_regs_t r, input logic [2:0] s);
        case (field_e'(s))
            F_SEC:   return r.sec;
            F_MIN:   return r.min;
            F_HOUR:  return r.hour;
            F_WDAY:  return r.wday;
            F_MDAY:  return r.mday;
            F_MON:   return r.mon;
            F_YEAR:  return r.year;
            default: return r.cent;
        endcase
    endfunction
endpackage

// File: rtl/cal_step_unit.sv
module cal_step_unit
    import rtc_cal_pkg::*;
#(
    parameter logic [DW-1:0] LO = 8'd0
) (
    input  logic          en,
    input  logic          bin_mode,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] hi,
    output logic [DW-1:0] nxt,
    output logic          carry
);
    logic [DW-1:0] b;
    logic          at_top;

    always_comb begin
        b      = to_bin(cur, bin_mode);
        at_top = (b >= hi);
        carry  = en && at_top;
        if (!en)
            nxt = cur;
        else if (at_top)
            nxt = enc(LO, bin_mode);
        else
            nxt = enc(b + 8'd1, bin_mode);
    end
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
    import rtc_cal_pkg::*;
(
    input  logic          en,
    input  logic          bin_mode,
    input  logic          fmt_24h,
    input  logic [DW-1:0] cur,
    output logic [DW-1:0] nxt,
    output logic          carry
);
    logic [DW-1:0] h12;
    logic [DW-1:0] h24;
    logic [DW-1:0] h24n;
    logic [DW-1:0] h12n;

    always_comb begin
        h12 = to_bin({1'b0, cur[6:0]}, bin_mode);
        if (fmt_24h)
            h24 = to_bin(cur, bin_mode);
        else
            h24 = (h12 % 8'd12) + (cur[7] ? 8'd12 : 8'd0);
        carry = en && (h24 >= 8'd23);
        h24n  = (h24 >= 8'd23) ? 8'd0 : h24 + 8'd1;
        h12n  = ((h24n % 8'd12) == 8'd0) ? 8'd12 : (h24n % 8'd12);
        if (!en)
            nxt = cur;
        else if (fmt_24h)
            nxt = enc(h24n, bin_mode);
        else
            nxt = {(h24n >= 8'd12), enc(h12n, bin_mode)[6:0]};
    end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import rtc_cal_pkg::*;
#(
    parameter logic [DW-1:0] RST_WDAY = 8'h03,
    parameter logic [DW-1:0] RST_YEAR = 8'h80,
    parameter logic [DW-1:0] RST_CENT = 8'h19,
    parameter logic [DW-1:0] CENT_LOAD = 8'd20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_stb,
    input  logic          bin_mode,
    input  logic          fmt_24h,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] sec_q,
    output logic [DW-1:0] min_q,
    output logic [DW-1:0] hour_q,
    output logic [DW-1:0] wday_q,
    output logic [DW-1:0] mday_q,
    output logic [DW-1:0] mon_q,
    output logic [DW-1:0] year_q,
    output logic [DW-1:0] cent_q
);
    cal_regs_t r_q, r_n;
    logic c_sec, c_min, c_hour, c_wday, c_mday, c_mon, c_year;
    logic [DW-1:0] mlen;
    logic [DW-1:0] year_b;
    logic [DW-1:0] cent_ld;

    assign year_b = to_bin(r_q.year, bin_mode);
    assign mlen   = month_len(to_bin(r_q.mon, bin_mode), (year_b[1:0] == 2'b00));

    cal_step_unit #(.LO(8'd0)) u_sec (.en(upd_stb), .bin_mode(bin_mode), .cur(r_q.sec),
        .hi(8'd59), .nxt(r_n.sec), .carry(c_sec));
    cal_step_unit #(.LO(8'd0)) u_min (.en(c_sec), .bin_mode(bin_mode), .cur(r_q.min),
        .hi(8'd59), .nxt(r_n.min), .carry(c_min));
    cal_hour_unit u_hour (.en(c_min), .bin_mode(bin_mode), .fmt_24h(fmt_24h),
        .cur(r_q.hour), .nxt(r_n.hour), .carry(c_hour));
    cal_step_unit #(.LO(8'd1)) u_wday (.en(c_hour), .bin_mode(bin_mode), .cur(r_q.wday),
        .hi(8'd7), .nxt(r_n.wday), .carry(c_wday));
    cal_step_unit #(.LO(8'd1)) u_mday (.en(c_hour), .bin_mode(bin_mode), .cur(r_q.mday),
        .hi(mlen), .nxt(r_n.mday), .carry(c_mday));
    cal_step_unit #(.LO(8'd1)) u_mon (.en(c_mday), .bin_mode(bin_mode), .cur(r_q.mon),
        .hi(8'd12), .nxt(r_n.mon), .carry(c_mon));
    cal_step_unit #(.LO(8'd0)) u_year (.en(c_mon), .bin_mode(bin_mode), .cur(r_q.year),
        .hi(8'd99), .nxt(r_n.year), .carry(c_year));

    assign cent_ld = enc(CENT_LOAD, bin_mode);
    assign r_n.cent = c_year ? {r_q.cent[7], cent_ld[6:0]} : r_q.cent;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: RST_WDAY,
                     mday: 8'h01, mon: 8'h01, year: RST_YEAR, cent: RST_CENT};
        end else if (wr_en) begin
            case (field_e'(wr_sel))
                F_SEC:   r_q.sec  <= wr_data;
                F_MIN:   r_q.min  <= wr_data;
                F_HOUR:  r_q.hour <= wr_data;
                F_WDAY:  r_q.wday <= wr_data;
                F_MDAY:  r_q.mday <= wr_data;
                F_MON:   r_q.mon  <= wr_data;
                F_YEAR:  r_q.year <= wr_data;
                default: r_q.cent <= wr_data;
            endcase
        end else if (upd_stb) begin
            r_q <= r_n;
        end
    end

    assign sec_q  = r_q.sec;
    assign min_q  = r_q.min;
    assign hour_q = r_q.hour;
    assign wday_q = r_q.wday;
    assign mday_q = r_q.mday;
    assign mon_q  = r_q.mon;
    assign year_q = r_q.year;
    assign cent_q = r_q.cent;

    // R11: idle cycles leave every register untouched
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!upd_stb && !wr_en) |=> $stable(r_q));
    // R10: written value lands in the selected register
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pick(r_q, $past(wr_sel)) == $past(wr_data)));
    // R9: century bit 7 is never altered by counting
    a_r9_cent_msb_kept: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (cent_q[7] == $past(cent_q[7])));
    // R2: every accepted strobe changes the seconds register
    a_r2_sec_moves: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && !wr_en) |=> (sec_q != $past(sec_q)));
    // R6: a weekday inside 1..7 stays inside 1..7
    a_r6_wday_range: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && !wr_en && wday_q >= 8'd1 && wday_q <= 8'd7)
        |=> (wday_q >= 8'd1 && wday_q <= 8'd7));
endmodule

// File: tb/sim_cal_counter.sv
module sim_cal_counter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_stb = 1'b0, bin_mode = 1'b0, fmt_24h = 1'b1, wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q, cent_q;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    cal_counter u0 (.clk(clk), .rst(rst), .upd_stb(upd_stb), .bin_mode(bin_mode),
        .fmt_24h(fmt_24h), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .wday_q(wday_q),
        .mday_q(mday_q), .mon_q(mon_q), .year_q(year_q), .cent_q(cent_q));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d, input logic with_stb);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d; upd_stb = with_stb;
        @(negedge clk);
        wr_en = 1'b0; upd_stb = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic load_all(input logic [7:0] s, m, h, wd, md, mo, y, c);
        wr(3'd0, s, 1'b0);  wr(3'd1, m, 1'b0);  wr(3'd2, h, 1'b0);  wr(3'd3, wd, 1'b0);
        wr(3'd4, md, 1'b0); wr(3'd5, mo, 1'b0); wr(3'd6, y, 1'b0);  wr(3'd7, c, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 sec", sec_q, 8'h00);   chk("R1 min", min_q, 8'h00);
        chk("R1 hour", hour_q, 8'h00); chk("R1 wday", wday_q, 8'h03);
        chk("R1 mday", mday_q, 8'h01); chk("R1 mon", mon_q, 8'h01);
        chk("R1 year", year_q, 8'h80); chk("R1 cent", cent_q, 8'h19);
    endtask

    task automatic t_bcd_seconds();
        bin_mode = 1'b0; fmt_24h = 1'b1;
        wr(3'd0, 8'h09, 1'b0); step();
        chk("R3 bcd 09->10", sec_q, 8'h10);
        wr(3'd1, 8'h00, 1'b0); wr(3'd0, 8'h59, 1'b0); step();
        chk("R2 sec wrap", sec_q, 8'h00);
        chk("R2 min carry", min_q, 8'h01);
    endtask

    task automatic t_hold();
        wr(3'd0, 8'h33, 1'b0);
        repeat (5) @(negedge clk);
        chk("R11 sec hold", sec_q, 8'h33);
        chk("R11 min hold", min_q, 8'h01);
    endtask

    task automatic t_bin_rollover();
        bin_mode = 1'b1; fmt_24h = 1'b1;
        wr(3'd0, 8'h09, 1'b0); step();
        chk("R3 bin 09->0A", sec_q, 8'h0A);
        load_all(8'd59, 8'd59, 8'd23, 8'd7, 8'd31, 8'd12, 8'd99, 8'h93);
        step();
        chk("R2 bin sec", sec_q, 8'h00);   chk("R2 bin min", min_q, 8'h00);
        chk("R4 bin hour", hour_q, 8'h00); chk("R6 wday wrap", wday_q, 8'h01);
        chk("R7 dec31", mday_q, 8'h01);    chk("R8 bin mon", mon_q, 8'h01);
        chk("R8 bin year", year_q, 8'h00); chk("R9 bin cent msb", cent_q, 8'h94);
    endtask

    task automatic t_bcd_rollover();
        bin_mode = 1'b0; fmt_24h = 1'b1;
        load_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h19);
        step();
        chk("R4 bcd hour", hour_q, 8'h00); chk("R6 bcd wday", wday_q, 8'h01);
        chk("R8 bcd mon", mon_q, 8'h01);   chk("R8 bcd year", year_q, 8'h00);
        chk("R9 bcd cent", cent_q, 8'h20);
    endtask

    task automatic t_12h();
        bin_mode = 1'b0; fmt_24h = 1'b0;
        load_all(8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h03, 8'h21, 8'h20);
        step();
        chk("R5 11AM->12PM", hour_q, 8'h92);
        wr(3'd1, 8'h59, 1'b0); wr(3'd0, 8'h59, 1'b0); step();
        chk("R5 12PM->1PM", hour_q, 8'h81);
        wr(3'd2, 8'h91, 1'b0); wr(3'd1, 8'h59, 1'b0); wr(3'd0, 8'h59, 1'b0); step();
        chk("R5 11PM->12AM", hour_q, 8'h12);
        chk("R5 day carry", mday_q, 8'h06);
        wr(3'd1, 8'h59, 1'b0); wr(3'd0, 8'h59, 1'b0); step();
        chk("R5 12AM->1AM", hour_q, 8'h01);
    endtask

    task automatic end_of_day(input logic [7:0] md, mo, y);
        load_all(8'h59, 8'h59, 8'h23, 8'h01, md, mo, y, 8'h20);
        step();
    endtask

    task automatic t_month_len();
        bin_mode = 1'b0; fmt_24h = 1'b1;
        end_of_day(8'h28, 8'h02, 8'h23);
        chk("R7 feb28 common mday", mday_q, 8'h01); chk("R7 feb28 common mon", mon_q, 8'h03);
        end_of_day(8'h28, 8'h02, 8'h24);
        chk("R7 feb28 leap", mday_q, 8'h29);        chk("R7 feb leap mon", mon_q, 8'h02);
        end_of_day(8'h29, 8'h02, 8'h24);
        chk("R7 feb29 leap", mday_q, 8'h01);        chk("R7 feb29 mon", mon_q, 8'h03);
        end_of_day(8'h30, 8'h04, 8'h24);
        chk("R7 apr30", mday_q, 8'h01);             chk("R7 apr30 mon", mon_q, 8'h05);
        end_of_day(8'h30, 8'h07, 8'h24);
        chk("R7 jul30", mday_q, 8'h31);
    endtask

    task automatic t_write_priority();
        bin_mode = 1'b0; fmt_24h = 1'b1;
        wr(3'd1, 8'h44, 1'b0);
        wr(3'd0, 8'h30, 1'b1);
        chk("R10 write wins", sec_q, 8'h30);
        chk("R10 other kept", min_q, 8'h44);
        wr(3'd7, 8'hA1, 1'b0);
        chk("R10 cent write", cent_q, 8'hA1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bcd_seconds();
        t_hold();
        t_bin_rollover();
        t_bcd_rollover();
        t_12h();
        t_month_len();
        t_write_priority();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule